// File: doc/BRIEF.md
# Partitioned Multi-Task Stack Buffer

One on-chip stack memory is split into equal regions, one per task. Every region is bounded by a lower and an upper limit register, and every task keeps a saved stack pointer. The active task pushes and pops through one working pointer. The top of its stack is readable combinationally at all times.

A context switch is requested with a strobe and a task index. On that edge, the working pointer of the outgoing task is written back to its slot. The incoming task's pointer and limits are then loaded. No stack entries are copied, so the incoming task can use its stack on the very next cycle. Accesses that would cross the active limits are refused and reported.

One region is designated the shared scratch region for low-priority tasks. Any copying of that region in or out of main memory is left to an outside agent. The block only signals when that region is the active one.

Top module: `mstk_part_buf`

## Requirements
- R1: After reset every task's stack is empty (saved pointer equals its region base), the active task is 0, `level_o` is 0 and both violation flags are low.
- R2: A push (`push_i` high, `pop_i` low) on a non-full active stack stores `push_data_i` at the active pointer. One cycle later `level_o` is one higher and `top_data_o` shows that value.
- R3: A push when `level_o` equals REGION_DEPTH (32) is refused. `overflow_o` is high for exactly the following cycle, and level and top are unchanged.
- R4: A pop (`pop_i` high, `push_i` low) on a non-empty active stack lowers `level_o` by one on the next cycle and exposes the entry beneath.
- R5: A pop when `level_o` is 0 is refused. `underflow_o` is high for exactly the following cycle, and the level stays 0.
- R6: With `switch_i` high, one cycle later `active_task_o` equals the sampled `task_sel_i`, and level and top reflect that task's saved stack. The outgoing task's level and entries are unchanged when it is selected again.
- R7: A push or pop in the same cycle as a switch is applied to the outgoing task before its pointer is saved.
- R8: `push_i` and `pop_i` high together change nothing and raise no flag.
- R9: `scratch_o` is high exactly while the active task is SCRATCH_TASK (default 3).
- R10: `top_valid_o` is high exactly when `level_o` is nonzero. While it is low, `top_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request for the active task |
| pop_i | input | 1 | Pop request for the active task |
| push_data_i | input | DATA_W (16) | Data to push |
| switch_i | input | 1 | Context switch strobe |
| task_sel_i | input | TASK_W (2) | Task to activate on a switch |
| top_data_o | output | DATA_W (16) | Top entry of the active stack, 0 when empty |
| top_valid_o | output | 1 | Active stack holds at least one entry |
| level_o | output | LVL_W (6) | Entries held by the active task |
| active_task_o | output | TASK_W (2) | Index of the active task |
| scratch_o | output | 1 | Active task owns the shared scratch region |
| overflow_o | output | 1 | Push was refused at the upper limit in the previous cycle |
| underflow_o | output | 1 | Pop was refused at the lower limit in the previous cycle |

## Verification
A pointer saved into the wrong slot, or loaded from one, shows up as a wrong `level_o` or `top_data_o` on the first cycle after a switch. It also shows up when a task is selected again and its old contents are read back. A limit register off by one either lets a 33rd push through or refuses the 32nd. `overflow_o` or `underflow_o` then appears one cycle late or early. The bench fills a full region and drains it across switches so that both symptoms surface within a few cycles of the fault.

// File: rtl/mstk_pkg.sv
package mstk_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/mstk_ctx_file.sv
module mstk_ctx_file #(
  parameter int NUM_TASKS    = 4,
  parameter int REGION_DEPTH = 32,
  parameter int PTR_W        = 8,
  parameter int TASK_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_en_i,
  input  logic [TASK_W-1:0] save_task_i,
  input  logic [PTR_W-1:0]  save_sp_i,
  input  logic [TASK_W-1:0] rd_task_i,
  output logic [PTR_W-1:0]  rd_sp_o,
  output logic [PTR_W-1:0]  rd_lo_o,
  output logic [PTR_W-1:0]  rd_hi_o
);
  logic [PTR_W-1:0] sp_q [NUM_TASKS];
  logic [PTR_W-1:0] lo_q [NUM_TASKS];
  logic [PTR_W-1:0] hi_q [NUM_TASKS];

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_ctx
    localparam logic [PTR_W-1:0] BASE  = PTR_W'(t * REGION_DEPTH);
    localparam logic [PTR_W-1:0] LIMIT = PTR_W'((t + 1) * REGION_DEPTH);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sp_q[t] <= BASE;
        lo_q[t] <= BASE;
        hi_q[t] <= LIMIT;
      end else if (save_en_i && save_task_i == TASK_W'(t)) begin
        sp_q[t] <= save_sp_i;
      end
    end
  end

  assign rd_sp_o = sp_q[rd_task_i];
  assign rd_lo_o = lo_q[rd_task_i];
  assign rd_hi_o = hi_q[rd_task_i];
endmodule

// File: rtl/mstk_guard.sv
module mstk_guard
  import mstk_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  stk_op_e          op_i,
  input  logic [PTR_W-1:0] sp_i,
  input  logic [PTR_W-1:0] lo_i,
  input  logic [PTR_W-1:0] hi_i,
  output logic             do_push_o,
  output logic             do_pop_o,
  output logic             ovf_o,
  output logic             udf_o,
  output logic [PTR_W-1:0] sp_next_o
);
  logic at_hi, at_lo;

  assign at_hi = (sp_i == hi_i);
  assign at_lo = (sp_i == lo_i);

  always_comb begin
    do_push_o = 1'b0;
    do_pop_o  = 1'b0;
    ovf_o     = 1'b0;
    udf_o     = 1'b0;
    sp_next_o = sp_i;
    unique case (op_i)
      OP_PUSH: begin
        ovf_o     = at_hi;
        do_push_o = !at_hi;
        if (!at_hi) sp_next_o = sp_i + PTR_W'(1);
      end
      OP_POP: begin
        udf_o    = at_lo;
        do_pop_o = !at_lo;
        if (!at_lo) sp_next_o = sp_i - PTR_W'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mstk_ram.sv
module mstk_ram #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mstk_part_buf.sv
module mstk_part_buf
  import mstk_pkg::*;
#(
  parameter int NUM_TASKS    = 4,
  parameter int REGION_DEPTH = 32,
  parameter int DATA_W       = 16,
  parameter int SCRATCH_TASK = 3,
  localparam int TOTAL       = NUM_TASKS * REGION_DEPTH,
  localparam int ADDR_W      = $clog2(TOTAL),
  localparam int PTR_W       = $clog2(TOTAL + 1),
  localparam int TASK_W      = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int LVL_W       = $clog2(REGION_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              switch_i,
  input  logic [TASK_W-1:0] task_sel_i,
  output logic [DATA_W-1:0] top_data_o,
  output logic              top_valid_o,
  output logic [LVL_W-1:0]  level_o,
  output logic [TASK_W-1:0] active_task_o,
  output logic              scratch_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  stk_op_e           op;
  logic [TASK_W-1:0] act_task_q;
  logic [PTR_W-1:0]  act_sp_q, act_lo_q, act_hi_q;
  logic [PTR_W-1:0]  sp_next, ld_sp, ld_lo, ld_hi, top_ptr;
  logic              do_push, do_pop, ovf, udf;
  logic              ovf_q, udf_q;
  logic [DATA_W-1:0] rd_data;

  always_comb begin
    if (push_i && !pop_i)      op = OP_PUSH;
    else if (pop_i && !push_i) op = OP_POP;
    else                       op = OP_NONE;
  end

  mstk_guard #(.PTR_W(PTR_W)) u_guard (
    .op_i      (op),
    .sp_i      (act_sp_q),
    .lo_i      (act_lo_q),
    .hi_i      (act_hi_q),
    .do_push_o (do_push),
    .do_pop_o  (do_pop),
    .ovf_o     (ovf),
    .udf_o     (udf),
    .sp_next_o (sp_next)
  );

  // outgoing pointer is saved after this cycle's access
  mstk_ctx_file #(
    .NUM_TASKS    (NUM_TASKS),
    .REGION_DEPTH (REGION_DEPTH),
    .PTR_W        (PTR_W),
    .TASK_W       (TASK_W)
  ) u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .save_en_i   (switch_i),
    .save_task_i (act_task_q),
    .save_sp_i   (sp_next),
    .rd_task_i   (task_sel_i),
    .rd_sp_o     (ld_sp),
    .rd_lo_o     (ld_lo),
    .rd_hi_o     (ld_hi)
  );

  mstk_ram #(
    .DEPTH  (TOTAL),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk_i   (clk_i),
    .we_i    (do_push),
    .waddr_i (act_sp_q[ADDR_W-1:0]),
    .wdata_i (push_data_i),
    .raddr_i (top_ptr[ADDR_W-1:0]),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_task_q <= '0;
      act_sp_q   <= '0;
      act_lo_q   <= '0;
      act_hi_q   <= PTR_W'(REGION_DEPTH);
      ovf_q      <= 1'b0;
      udf_q      <= 1'b0;
    end else begin
      ovf_q <= ovf;
      udf_q <= udf;
      if (switch_i) begin
        act_task_q <= task_sel_i;
        act_lo_q   <= ld_lo;
        act_hi_q   <= ld_hi;
        // reselecting the active task keeps the live pointer
        act_sp_q   <= (task_sel_i == act_task_q) ? sp_next : ld_sp;
      end else begin
        act_sp_q <= sp_next;
      end
    end
  end

  logic [PTR_W-1:0] depth;

  assign top_ptr       = act_sp_q - PTR_W'(1);
  assign depth         = act_sp_q - act_lo_q;
  assign top_valid_o   = (act_sp_q != act_lo_q);
  assign top_data_o    = top_valid_o ? rd_data : '0;
  assign level_o       = depth[LVL_W-1:0];
  assign active_task_o = act_task_q;
  assign scratch_o     = (act_task_q == TASK_W'(SCRATCH_TASK));
  assign overflow_o    = ovf_q;
  assign underflow_o   = udf_q;
endmodule

// File: rtl/mstk_part_buf_chk.sv
module mstk_part_buf_chk #(
  parameter int REGION_DEPTH = 32,
  parameter int DATA_W       = 16,
  parameter int TASK_W       = 2,
  parameter int LVL_W        = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] push_data_i,
  input logic              switch_i,
  input logic [TASK_W-1:0] task_sel_i,
  input logic [DATA_W-1:0] top_data_o,
  input logic              top_valid_o,
  input logic [LVL_W-1:0]  level_o,
  input logic              overflow_o,
  input logic              underflow_o
);
  assert_push_grows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !switch_i && level_o != LVL_W'(REGION_DEPTH))
    |=> (level_o == $past(level_o) + LVL_W'(1)) && (top_data_o == $past(push_data_i)));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !switch_i && level_o == LVL_W'(REGION_DEPTH))
    |=> overflow_o && $stable(level_o) && $stable(top_data_o));

  assert_pop_shrinks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !switch_i && level_o != '0)
    |=> level_o == $past(level_o) - LVL_W'(1));

  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !switch_i && level_o == '0)
    |=> underflow_o && level_o == '0);

  assert_both_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !switch_i)
    |=> $stable(level_o) && !overflow_o && !underflow_o);

  assert_flags_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(overflow_o && underflow_o));

  assert_empty_top_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !top_valid_o |-> top_data_o == '0);
endmodule

bind mstk_part_buf mstk_part_buf_chk #(
  .REGION_DEPTH (REGION_DEPTH),
  .DATA_W       (DATA_W),
  .TASK_W       (TASK_W),
  .LVL_W        (LVL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .push_data_i (push_data_i),
  .switch_i    (switch_i),
  .task_sel_i  (task_sel_i),
  .top_data_o  (top_data_o),
  .top_valid_o (top_valid_o),
  .level_o     (level_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o)
);

// File: tb/mstk_part_buf_tb_top.sv
module mstk_part_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int RD = 32;

  typedef struct {
    int    lvl;
    int    top;
    int    tsk;
    bit    ovf;
    bit    udf;
    bit    scr;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0, sw = 1'b0;
  logic [15:0] wdata = '0;
  logic [1:0]  sel = '0;
  logic [15:0] top_data;
  logic        top_valid, scratch, ovf, udf;
  logic [5:0]  level;
  logic [1:0]  act_task;

  int   n_checks = 0, n_fail = 0;
  int   mdl [NT][RD];
  int   mlvl [NT];
  int   mact = 0;
  exp_t exp_q [$];
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mstk_part_buf dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .push_i (push), .pop_i (pop), .push_data_i (wdata),
    .switch_i (sw), .task_sel_i (sel),
    .top_data_o (top_data), .top_valid_o (top_valid), .level_o (level),
    .active_task_o (act_task), .scratch_o (scratch),
    .overflow_o (ovf), .underflow_o (udf)
  );

  task automatic chk(input string req, input string what, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic op(input bit p, input bit q, input int d, input bit s, input int t, input string req);
    exp_t e;
    @(negedge clk);
    push = p; pop = q; wdata = 16'(d); sw = s; sel = 2'(t);
    e.ovf = 0; e.udf = 0;
    if (p && !q) begin
      if (mlvl[mact] == RD) e.ovf = 1;
      else begin mdl[mact][mlvl[mact]] = d; mlvl[mact]++; end
    end else if (q && !p) begin
      if (mlvl[mact] == 0) e.udf = 1;
      else mlvl[mact]--;
    end
    if (s) mact = t;
    e.tsk = mact;
    e.lvl = mlvl[mact];
    e.top = (mlvl[mact] > 0) ? mdl[mact][mlvl[mact]-1] : 0;
    e.scr = (mact == 3);
    e.req = req;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  // monitor: compares one expectation per cycle, after the edge that produced it
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(e.req, "level", int'(level), e.lvl);
        chk(e.req, "top", int'(top_data), e.top);
        chk("R10", "top_valid", int'(top_valid), int'(e.lvl > 0));
        chk("R6", "task", int'(act_task), e.tsk);
        chk("R9", "scratch", int'(scratch), int'(e.scr));
        chk("R3", "overflow", int'(ovf), int'(e.ovf));
        chk("R5", "underflow", int'(udf), int'(e.udf));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    foreach (mlvl[i]) mlvl[i] = 0;
    #(CLK_PERIOD * 3 + 2);
    rst_n = 1'b1;
    // R1 reset state
    op(0, 0, 0, 0, 0, "R1");
    // R2 pushes on task 0
    op(1, 0, 16'h1111, 0, 0, "R2");
    op(1, 0, 16'h2222, 0, 0, "R2");
    op(1, 0, 16'h3333, 0, 0, "R2");
    // R4 pop
    op(0, 1, 0, 0, 0, "R4");
    // R8 push+pop together
    op(1, 1, 16'hdead, 0, 0, "R8");
    // R6 switch to task 1, push there, return
    op(0, 0, 0, 1, 1, "R6");
    op(1, 0, 16'hA001, 0, 1, "R6");
    // R7 push in the same cycle as switch goes to task 1
    op(1, 0, 16'hA002, 1, 0, "R7");
    op(0, 0, 0, 1, 1, "R7");
    // R7 pop in the same cycle as switch
    op(0, 1, 0, 1, 0, "R7");
    op(0, 0, 0, 1, 1, "R6");
    // R5 drain task 1 past empty
    op(0, 1, 0, 0, 1, "R4");
    op(0, 1, 0, 0, 1, "R5");
    // R9 scratch task 3, then fill task 2 to overflow
    op(0, 0, 0, 1, 3, "R9");
    op(1, 0, 16'h0777, 0, 3, "R9");
    op(0, 0, 0, 1, 2, "R6");
    for (int i = 0; i < RD; i++) op(1, 0, 16'h5000 + i, 0, 2, "R2");
    op(1, 0, 16'hbeef, 0, 2, "R3");
    op(1, 0, 16'hbeef, 0, 2, "R3");
    // reselect same task keeps pointer
    op(1, 1, 0, 1, 2, "R6");
    for (int i = 0; i < RD; i++) op(0, 1, 0, 0, 2, "R4");
    op(0, 1, 0, 0, 2, "R5");
    // neighbours untouched
    op(0, 0, 0, 1, 3, "R6");
    op(0, 0, 0, 1, 0, "R6");
    op(0, 1, 0, 0, 0, "R4");
    op(0, 1, 0, 0, 0, "R4");
    op(0, 1, 0, 0, 0, "R5");
    op(0, 0, 0, 0, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule